// File: doc/BRIEF.md
# Burst Input Data Assembler

This block brings 14-bit samples from an external parallel bus into a modulator signal chain. Everything runs on one fast system clock. A programmable divider produces a base rate every N system cycles. From it come a port-clock level that toggles at the base rate, so it has a period of 2N cycles, and a chain-clock level that toggles on each port-clock rising edge, so it has a period of 4N cycles. Words on the bus are captured on port-clock rising edges. Words alternate as in-phase and quadrature and are joined into pairs. Each pair is handed to the chain on a rising edge of the chain clock.

A burst-start pulse restarts the divider from a known phase, which is chosen by an input. If the first port-clock edge of the burst drives the chain clock high, each assembled pair waits half a chain period before it is taken. If that first edge drives the chain clock low, each pair waits a full chain period. The two alignments therefore differ by one port-clock period, which is 2N system cycles. A status output reports which alignment the current burst uses.

Top module: `burst_data_assembler`

## Requirements
- R1: After reset, and until the first burst start, `pair_valid`, `pair_data` and `full_align` are all 0, and activity on `din` produces no output.
- R2: The divide factor N is latched at burst start. N equals `rate_sel` for values 2 to 63. A `rate_sel` of 0 or 1 is bypass, where N equals 1 and a port capture can occur every 2 cycles.
- R3: The first port capture happens at the clock edge N cycles after the burst-start edge when `init_high` is 0, and 2N cycles after it when `init_high` is 1. Later captures follow every 2N cycles.
- R4: The first word captured after burst start is in-phase and the next is quadrature, alternating from there. A pair is output as `pair_data[27:14]` = in-phase and `pair_data[13:0]` = quadrature.
- R5: `pair_valid` is a one-cycle pulse, and consecutive pairs of a burst are 4N cycles apart.
- R6: With `init_high` = 0, a pair whose in-phase word was captured at port edge k is output on port edge k+4, which is 8N cycles later. `full_align` reads 0 after the first port edge.
- R7: With `init_high` = 1, the same pair is output on port edge k+5, which is 10N cycles later. `full_align` reads 1 after the first port edge.
- R8: A change of `rate_sel` while a burst is running has no effect on its timing until the next burst start.
- R9: A burst start in the middle of a burst discards every word and pair not yet output. The next captured word is treated as in-phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | One-cycle pulse that starts a burst and restarts the divider phase |
| rate_sel | input | 6 | Divide factor N; 0 or 1 selects bypass (N = 1) |
| init_high | input | 1 | Starting level of the port and chain clocks at burst start |
| din | input | 14 | Interleaved in-phase and quadrature sample bus |
| pair_data | output | 28 | Assembled pair, in-phase in the upper half |
| pair_valid | output | 1 | One-cycle strobe when a pair is handed to the chain |
| full_align | output | 1 | 1 when the burst uses the full-period alignment |

## Verification
The hardest behaviour to reach from the ports is the full-period alignment. In that case a freshly assembled pair and the previous pair's hand-off fall on the same clock edge. The bench reaches it by starting bursts with `init_high` set, at several values of N including bypass and the largest factor. It drives each word only in the window that ends at its computed capture edge. It then checks that every pulse lands exactly 10N cycles after the capture of the pair's in-phase word, and that no other pulse appears.

// File: rtl/burst_asm_pkg.sv
package burst_asm_pkg;
  localparam int SAMPLE_W_DEF = 14;
  localparam int RATE_W_DEF   = 6;

  typedef enum logic {
    LANE_I = 1'b0,
    LANE_Q = 1'b1
  } lane_e;
endpackage

// File: rtl/rate_phase_gen.sv
module rate_phase_gen #(
  parameter int RATE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_start,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              init_high,
  output logic              port_tick,
  output logic              lvl2n,
  output logic              lvl4n,
  output logic              full_align
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);
  localparam logic [RATE_W-1:0] TWO = RATE_W'(2);

  logic [RATE_W-1:0] n_q;
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] eff_n;
  logic              active_q;
  logic              lvl2_q;
  logic              lvl4_q;
  logic              first_q;
  logic              full_q;
  logic              base_tick;

  // bypass folds 0 and 1 onto a factor of one
  assign eff_n     = (rate_sel < TWO) ? ONE : rate_sel;
  assign base_tick = active_q && !burst_start && (cnt_q == n_q - ONE);
  assign port_tick = base_tick && !lvl2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q      <= ONE;
      cnt_q    <= '0;
      active_q <= 1'b0;
      lvl2_q   <= 1'b0;
      lvl4_q   <= 1'b0;
      first_q  <= 1'b0;
      full_q   <= 1'b0;
    end else if (burst_start) begin
      n_q      <= eff_n;
      cnt_q    <= '0;
      active_q <= 1'b1;
      lvl2_q   <= init_high;
      lvl4_q   <= init_high;
      first_q  <= 1'b1;
      full_q   <= 1'b0;
    end else if (active_q) begin
      cnt_q <= base_tick ? '0 : cnt_q + ONE;
      if (base_tick) begin
        lvl2_q <= ~lvl2_q;
      end
      if (port_tick) begin
        lvl4_q <= ~lvl4_q;
        if (first_q) begin
          first_q <= 1'b0;
          full_q  <= lvl4_q;
        end
      end
    end
  end

  assign lvl2n      = lvl2_q;
  assign lvl4n      = lvl4_q;
  assign full_align = full_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < n_q);

  // R8
  rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !burst_start |=> $stable(n_q));

  // R3
  chain_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lvl4_q) && !$past(burst_start)) |-> $rose(lvl2_q));
endmodule

// File: rtl/capture_pairer.sv
module capture_pairer
  import burst_asm_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int STAGES   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  burst_start,
  input  logic                  port_tick,
  input  logic [SAMPLE_W-1:0]   din,
  output logic [2*SAMPLE_W-1:0] pair_q,
  output logic                  pair_fresh
);
  localparam int QS = STAGES - 2;
  localparam int IS = STAGES - 1;

  logic [SAMPLE_W-1:0] stg_data [STAGES];
  lane_e               stg_lane [STAGES];
  logic [STAGES-1:0]   stg_vld;
  lane_e               next_lane;
  logic [2*SAMPLE_W-1:0] pair_r;
  logic                  fresh_r;
  logic                  join_now;

  assign join_now = port_tick && stg_vld[QS] && stg_vld[IS] &&
                    (stg_lane[QS] == LANE_Q);

  always_ff @(posedge clk) begin
    if (rst || burst_start) begin
      stg_vld   <= '0;
      next_lane <= LANE_I;
      for (int i = 0; i < STAGES; i++) begin
        stg_data[i] <= '0;
        stg_lane[i] <= LANE_I;
      end
    end else if (port_tick) begin
      stg_data[0] <= din;
      stg_lane[0] <= next_lane;
      stg_vld[0]  <= 1'b1;
      next_lane   <= (next_lane == LANE_I) ? LANE_Q : LANE_I;
      for (int i = 1; i < STAGES; i++) begin
        stg_data[i] <= stg_data[i-1];
        stg_lane[i] <= stg_lane[i-1];
        stg_vld[i]  <= stg_vld[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_r  <= '0;
      fresh_r <= 1'b0;
    end else begin
      fresh_r <= join_now && !burst_start;
      if (join_now) begin
        pair_r <= {stg_data[IS], stg_data[QS]};
      end
    end
  end

  assign pair_q     = pair_r;
  assign pair_fresh = fresh_r;

  // R4
  pair_order_chk: assert property (@(posedge clk) disable iff (rst)
    pair_fresh |-> $past(port_tick));
endmodule

// File: rtl/chain_sampler.sv
module chain_sampler #(
  parameter int PAIR_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_start,
  input  logic              port_tick,
  input  logic              lvl4n,
  input  logic [PAIR_W-1:0] pair_in,
  input  logic              pair_fresh,
  output logic [PAIR_W-1:0] pair_data,
  output logic              pair_valid
);
  logic              pending_q;
  logic              take;
  logic [PAIR_W-1:0] data_q;
  logic              valid_q;

  assign take = port_tick && !lvl4n && pending_q;

  always_ff @(posedge clk) begin
    if (rst || burst_start) begin
      pending_q <= 1'b0;
      valid_q   <= 1'b0;
      if (rst) begin
        data_q <= '0;
      end
    end else begin
      valid_q <= take;
      if (take) begin
        data_q <= pair_in;
      end
      if (pair_fresh) begin
        pending_q <= 1'b1;
      end else if (take) begin
        pending_q <= 1'b0;
      end
    end
  end

  assign pair_data  = data_q;
  assign pair_valid = valid_q;

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  // R6
  rise_align_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> $rose(lvl4n));
endmodule

// File: rtl/burst_data_assembler.sv
module burst_data_assembler
  import burst_asm_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int RATE_W   = RATE_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  burst_start,
  input  logic [RATE_W-1:0]     rate_sel,
  input  logic                  init_high,
  input  logic [SAMPLE_W-1:0]   din,
  output logic [2*SAMPLE_W-1:0] pair_data,
  output logic                  pair_valid,
  output logic                  full_align
);
  localparam int PAIR_W      = 2 * SAMPLE_W;
  localparam int PIPE_STAGES = 3;

  logic              port_tick;
  logic              lvl2n;
  logic              lvl4n;
  logic [PAIR_W-1:0] pair_w;
  logic              fresh_w;

  rate_phase_gen #(.RATE_W(RATE_W)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .burst_start (burst_start),
    .rate_sel    (rate_sel),
    .init_high   (init_high),
    .port_tick   (port_tick),
    .lvl2n       (lvl2n),
    .lvl4n       (lvl4n),
    .full_align  (full_align)
  );

  capture_pairer #(.SAMPLE_W(SAMPLE_W), .STAGES(PIPE_STAGES)) u_pair (
    .clk         (clk),
    .rst         (rst),
    .burst_start (burst_start),
    .port_tick   (port_tick),
    .din         (din),
    .pair_q      (pair_w),
    .pair_fresh  (fresh_w)
  );

  chain_sampler #(.PAIR_W(PAIR_W)) u_chain (
    .clk         (clk),
    .rst         (rst),
    .burst_start (burst_start),
    .port_tick   (port_tick),
    .lvl4n       (lvl4n),
    .pair_in     (pair_w),
    .pair_fresh  (fresh_w),
    .pair_data   (pair_data),
    .pair_valid  (pair_valid)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && !$past(pair_valid)) |-> !$past(burst_start));
endmodule

// File: tb/burst_data_assembler_tb.sv
`timescale 1ns/1ps
module burst_data_assembler_tb;
  localparam real CLK_NS = 8.0;
  localparam int  ROWS   = 8;

  // stimulus columns: rate, init, mid-burst rate change, words
  // expected columns: full_align, port edges from I capture to output
  localparam int T_RATE [ROWS] = '{2, 2, 3, 5, 0, 1, 63, 4};
  localparam int T_INIT [ROWS] = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int T_CHG  [ROWS] = '{0, 0, 0, 1, 0, 0, 0, 1};
  localparam int T_WORD [ROWS] = '{8, 8, 6, 6, 8, 6, 4, 4};
  localparam int T_FULL [ROWS] = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int T_LAT  [ROWS] = '{4, 5, 4, 5, 4, 5, 4, 5};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        burst_start = 1'b0;
  logic [5:0]  rate_sel = 6'd2;
  logic        init_high = 1'b0;
  logic [13:0] din = '0;
  logic [27:0] pair_data;
  logic        pair_valid;
  logic        full_align;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  burst_data_assembler u_dut (
    .clk         (clk),
    .rst         (rst),
    .burst_start (burst_start),
    .rate_sel    (rate_sel),
    .init_high   (init_high),
    .din         (din),
    .pair_data   (pair_data),
    .pair_valid  (pair_valid),
    .full_align  (full_align)
  );

  function automatic logic [13:0] wgen(input int row, input int k);
    return 14'((row * 613 + k * 97 + 11) ^ (k << 9));
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_burst(input int row, input int rate_raw, input int init,
                           input int chg, input int nw, input int exp_full,
                           input int lat);
    int n    = (rate_raw < 2) ? 1 : rate_raw;
    int off  = (init != 0) ? 2 * n : n;
    int np   = nw / 2;
    int last = off + 2 * n * (2 * (np - 1) + lat) + 1;
    int seen = 0;
    @(negedge clk);
    burst_start = 1'b1;
    rate_sel    = 6'(rate_raw);
    init_high   = 1'(init);
    din         = wgen(row, 0);
    @(posedge clk);
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      burst_start = 1'b0;
      if (chg != 0) rate_sel = 6'd9;  // R8 change ignored mid-burst
      if (c == off) begin
        chk(full_align == 1'(exp_full), (exp_full != 0) ? "R7 status" : "R6 status",
            28'(full_align), 28'(exp_full));
      end
      if (pair_valid) begin
        int rel = c - off - 2 * n * lat;
        if (rel >= 0 && (rel % (4 * n)) == 0 && (rel / (4 * n)) < np) begin
          int j = rel / (4 * n);
          seen++;
          // R4 pairing order, R5 spacing, R6/R7 latency, R2 factor
          chk(pair_data == {wgen(row, 2 * j), wgen(row, 2 * j + 1)},
              (lat == 5) ? "R7 R4 pair" : "R6 R4 pair",
              pair_data, {wgen(row, 2 * j), wgen(row, 2 * j + 1)});
        end else begin
          chk(1'b0, "R5 R3 unexpected pulse", 28'(c), 28'(rel));
        end
      end
      begin
        int k = (c + 1 <= off) ? 0 : (c + 1 - off + 2 * n - 1) / (2 * n);
        din = (k < nw) ? wgen(row, k) : 14'h0;
      end
    end
    chk(seen == np, "R5 R2 pair count", 28'(seen), 28'(np));
  endtask

  initial begin
    #(CLK_NS * 200000.0);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit stray;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pair_valid == 1'b0, "R1 valid", 28'(pair_valid), 28'h0);
    chk(pair_data == 28'h0, "R1 data", pair_data, 28'h0);
    chk(full_align == 1'b0, "R1 status", 28'(full_align), 28'h0);
    stray = 1'b0;
    for (int i = 0; i < 40; i++) begin
      din = 14'(i * 331);
      @(negedge clk);
      if (pair_valid) stray = 1'b1;
    end
    chk(!stray, "R1 idle no output", 28'(stray), 28'h0);

    // table walk
    for (int r = 0; r < ROWS; r++) begin
      run_burst(r, T_RATE[r], T_INIT[r], T_CHG[r], T_WORD[r], T_FULL[r], T_LAT[r]);
    end

    // R9 restart mid-burst: three words captured, no pair out yet
    @(negedge clk);
    burst_start = 1'b1;
    rate_sel    = 6'd2;
    init_high   = 1'b0;
    din         = 14'h3FFF;
    stray = 1'b0;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      burst_start = 1'b0;
      din = 14'(14'h3000 + i);
      if (pair_valid) stray = 1'b1;
    end
    chk(!stray, "R9 no pulse before restart", 28'(stray), 28'h0);
    run_burst(20, 2, 1, 0, 6, 1, 5);

    // R8 large rate change mid-burst with the bypass factor latched
    run_burst(21, 1, 0, 1, 4, 0, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule